// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for the device side of a three-wire serial EEPROM that stores 16-bit words. A host drives chip select, a serial clock and a data input. The block samples all three with the system clock and finds serial clock rising edges itself. Each command begins with a start bit (a 1), then a two-bit opcode, then an address field of `ADDR_W` bits. Write commands then carry 16 data bits. Read commands return data on a tri-stateable output, given here as a data bit plus an output-enable.

Modifying commands are write, erase one word, erase all words and write all words. All of them are guarded by a write-enable latch, while read is always allowed. A modifying command only begins on the falling edge of chip select after the command is complete. It then keeps the block busy for a fixed number of system clock cycles. If chip select is raised during that time, the output reports busy or ready. The storage is a plain register array with one write port and one synchronous read port, so it maps onto block RAM. The two whole-array commands sweep the array one word per cycle inside the busy window.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear and `do_oe_o` is 0. A modifying command sent before any enable command is ignored: no busy status appears and no word changes.
- R2: The opcode is the two bits after the start bit: 10 read, 01 write, 11 erase, 00 extended. Within an extended command the two most significant address bits select the action: 11 enable, 00 disable, 10 erase all, 01 write all. Enable sets the latch and disable clears it, each on the following chip select fall. The latch keeps its value across any number of other commands. While it is clear, modifying commands are ignored.
- R3: A read works whatever the latch holds. Once the last address bit is clocked in, `do_oe_o` goes to 1 and `do_o` shows a dummy 0. Each further rising edge of the serial clock then presents the next of the 16 data bits, most significant bit first.
- R4: A write takes 16 data bits, most significant bit first, after the address. With the latch set, it stores them at the address.
- R5: An erase sets the addressed word to 16'hFFFF and leaves every other word as it was.
- R6: Erase all sets every word to 16'hFFFF.
- R7: Write all stores the 16 data bits that follow the address field into every word.
- R8: A modifying command starts only when chip select falls after its final bit. If chip select falls before the command is complete, nothing happens and no busy status follows.
- R9: Once an accepted command starts, raising chip select drives `do_oe_o`=1. `do_o`=0 for exactly `max(BUSY_CYC, 2**ADDR_W)` cycles, then `do_o`=1. With chip select low, `do_oe_o` is 0.
- R10: `do_oe_o` stays 0 during the entry of enable, disable, erase, erase-all, write and write-all commands.
- R11: Extra serial clocks after an enable, disable or erase command is complete have no effect on that command.
- R12: While busy, start bits and whole commands are ignored. The status output keeps showing busy.
- R13: Zeros clocked in before the start bit are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled on rising edges |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out (read data or busy/ready status) |
| do_oe_o | output | 1 | Output enable for `do_o`; 0 means high impedance |

## Verification
The bench goes after the latch edge cases. A write straight after reset, a write after disable, and enable or erase followed by extra clocks are all included. A design that powers up enabled, or that lets trailing clocks flip the latch, would change words that later reads compare. A write cut off after ten data bits checks that an aborted command leaves no trace: a design that committed partial data would show busy status and a changed word. A complete write is sent while another operation is still busy, to catch a design that accepts commands mid-operation. A design that misplaces the dummy bit or stores bits in the wrong order fails the read checks.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_ERASE, K_WEN, K_WDS, K_ERAL, K_WRAL
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_DONE, ST_BUSY
  } state_e;

  function automatic kind_e decode_kind(input logic [1:0] op, input logic [1:0] sub);
    kind_e k;
    case (op_e'(op))
      OP_READ:  k = K_READ;
      OP_WRITE: k = K_WRITE;
      OP_ERASE: k = K_ERASE;
      default: begin
        case (sub)
          2'b11:   k = K_WEN;
          2'b00:   k = K_WDS;
          2'b10:   k = K_ERAL;
          default: k = K_WRAL;
        endcase
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/uwire_sync.sv
module uwire_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_q,
  output logic di_q,
  output logic sk_rise
);
  logic sk_q, sk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
      sk_d <= 1'b0;
      di_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      sk_d <= sk_q;
      di_q <= di;
    end
  end

  assign sk_rise = sk_q & ~sk_d;
endmodule

// File: rtl/uwire_mem.sv
module uwire_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              di_q,
  input  logic              sk_rise,
  input  logic [DATA_W-1:0] rd_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              do_q,
  output logic              do_oe,
  output logic              busy,
  output logic              wen
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CMD_W    = 2 + ADDR_W;
  localparam int BUSY_LEN = (BUSY_CYC > DEPTH) ? BUSY_CYC : DEPTH;
  localparam int TW       = $clog2(BUSY_LEN + 1);
  localparam int BMAX     = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BW       = $clog2(BMAX + 1);
  localparam logic [TW-1:0] LAST_T    = TW'(BUSY_LEN - 1);
  localparam logic [TW-1:0] DEPTH_T   = TW'(DEPTH);
  localparam logic [BW-1:0] CMD_LAST  = BW'(CMD_W - 1);
  localparam logic [BW-1:0] DATA_LAST = BW'(DATA_W - 1);

  state_e              state;
  kind_e               kind;
  kind_e               kind_nx;
  logic [CMD_W-2:0]    cmd_sr;
  logic [CMD_W-1:0]    cmd_nx;
  logic [DATA_W-1:0]   dat_sr;
  logic [DATA_W-1:0]   out_sr;
  logic [BW-1:0]       bcnt;
  logic [TW-1:0]       tcnt;
  logic                stat_en;
  logic                rd_first;
  logic                all_op;

  assign cmd_nx  = {cmd_sr, di_q};
  assign kind_nx = decode_kind(cmd_nx[CMD_W-1 -: 2], cmd_nx[ADDR_W-1 -: 2]);
  assign rd_addr = cmd_sr[ADDR_W-1:0];
  assign busy    = (state == ST_BUSY);

  // Memory write port: single ops write once, whole-array ops sweep
  always_comb begin
    all_op    = (kind == K_ERAL) || (kind == K_WRAL);
    mem_we    = busy && (all_op ? (tcnt < DEPTH_T) : (tcnt == '0));
    mem_waddr = all_op ? tcnt[ADDR_W-1:0] : cmd_sr[ADDR_W-1:0];
    mem_wdata = ((kind == K_ERASE) || (kind == K_ERAL)) ? '1 : dat_sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= K_NONE;
      cmd_sr   <= '0;
      dat_sr   <= '0;
      out_sr   <= '0;
      bcnt     <= '0;
      tcnt     <= '0;
      wen      <= 1'b0;
      stat_en  <= 1'b0;
      rd_first <= 1'b0;
      do_q     <= 1'b0;
      do_oe    <= 1'b0;
    end else if (state == ST_BUSY) begin
      // status only; serial input ignored
      do_oe <= cs_q & stat_en;
      do_q  <= 1'b0;
      if (tcnt == LAST_T) begin
        state <= ST_IDLE;
        tcnt  <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end else if (!cs_q) begin
      do_oe    <= 1'b0;
      do_q     <= 1'b0;
      rd_first <= 1'b0;
      state    <= ST_IDLE;
      if (state == ST_DONE) begin
        case (kind)
          K_WEN: wen <= 1'b1;
          K_WDS: wen <= 1'b0;
          K_WRITE, K_ERASE, K_ERAL, K_WRAL: begin
            if (wen) begin
              state   <= ST_BUSY;
              tcnt    <= '0;
              stat_en <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else begin
      case (state)
        ST_IDLE: begin
          do_oe <= stat_en;
          do_q  <= 1'b1;
          if (sk_rise && di_q) begin
            state   <= ST_CMD;
            bcnt    <= '0;
            stat_en <= 1'b0;
            do_oe   <= 1'b0;
          end
        end
        ST_CMD: begin
          if (sk_rise) begin
            cmd_sr <= cmd_nx[CMD_W-2:0];
            bcnt   <= bcnt + 1'b1;
            if (bcnt == CMD_LAST) begin
              kind <= kind_nx;
              bcnt <= '0;
              case (kind_nx)
                K_READ: begin
                  state    <= ST_READ;
                  do_oe    <= 1'b1;
                  do_q     <= 1'b0;
                  rd_first <= 1'b1;
                end
                K_WRITE, K_WRAL: state <= ST_DATA;
                default:         state <= ST_DONE;
              endcase
            end
          end
        end
        ST_DATA: begin
          if (sk_rise) begin
            dat_sr <= {dat_sr[DATA_W-2:0], di_q};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == DATA_LAST) state <= ST_DONE;
          end
        end
        ST_READ: begin
          if (sk_rise) begin
            rd_first <= 1'b0;
            if (rd_first) begin
              do_q   <= rd_q[DATA_W-1];
              out_sr <= {rd_q[DATA_W-2:0], 1'b0};
            end else begin
              do_q   <= out_sr[DATA_W-1];
              out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_q, di_q, sk_rise;
  logic [DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0] rd_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              busy_w;
  logic              wen_w;

  uwire_sync u_sync (
    .clk(clk), .rst(rst), .cs(cs_i), .sk(sk_i), .di(di_i),
    .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise)
  );

  uwire_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise),
    .rd_q(rd_q), .rd_addr(rd_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .do_q(do_o), .do_oe(do_oe_o),
    .busy(busy_w), .wen(wen_w)
  );

  uwire_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_q)
  );
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk #(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 120
) (
  input logic clk,
  input logic rst,
  input logic cs,
  input logic do_oe,
  input logic busy,
  input logic wen,
  input logic mem_we
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BUSY_LEN = (BUSY_CYC > DEPTH) ? BUSY_CYC : DEPTH;

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else     busy_run <= busy ? busy_run + 1 : 0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!do_oe && !wen)); // R1

  AST_GUARDED_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wen); // R2

  AST_START_AFTER_CS_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(cs, 2)); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == BUSY_LEN)); // R9

  AST_CS_LOW_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!cs && $past(!cs)) |=> !do_oe); // R9
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .cs(cs_i), .do_oe(do_oe_o),
  .busy(busy_w), .wen(wen_w), .mem_we(mem_we)
);

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 16;
  localparam int BUSY_CYC = 240;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BUSY_LEN = (BUSY_CYC > DEPTH) ? BUSY_CYC : DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_q, do_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [DATA_W-1:0] mem_m [DEPTH];
  bit wen_m = 0;

  always #2 clk = ~clk;

  uwire_eeprom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_q), .do_oe_o(do_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ext_addr(input logic [1:0] code);
    logic [ADDR_W-3:0] low;
    low = (ADDR_W-2)'($urandom);
    return {code, low};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di = b; tick(2);
    sk = 1'b1; tick(3);
    sk = 1'b0; tick(2);
  endtask

  task automatic cs_up();
    cs = 1'b1; tick(3);
  endtask

  task automatic cs_down();
    cs = 1'b0; sk = 1'b0; di = 1'b0; tick(3);
  endtask

  task automatic send_cmd(input int zeros, input logic [1:0] op, input logic [ADDR_W-1:0] a);
    for (int i = 0; i < zeros; i++) pulse(1'b0);
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = ADDR_W-1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_data(input logic [DATA_W-1:0] d, input int nbits);
    for (int i = 0; i < nbits; i++) pulse(d[DATA_W-1-i]);
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) pulse(1'($urandom));
  endtask

  // after chip select has fallen: probe status
  task automatic finish_mod(input bit accepted, input string tag);
    cs_up();
    if (accepted) begin
      chk({tag, " busy oe"}, {31'd0, do_oe}, 32'd1);
      chk({tag, " busy low"}, {31'd0, do_q}, 32'd0);
      tick(BUSY_LEN + 4);
      chk({tag, " ready high"}, {31'd0, do_q}, 32'd1);
    end else begin
      chk({tag, " ignored no status"}, {31'd0, do_oe}, 32'd0);
    end
    cs_down();
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input int zeros);
    logic [DATA_W-1:0] w;
    cs_up();
    send_cmd(zeros, 2'b10, a);
    chk("R3 dummy oe", {31'd0, do_oe}, 32'd1);
    chk("R3 dummy zero", {31'd0, do_q}, 32'd0);
    for (int i = 0; i < DATA_W; i++) begin
      pulse(1'b0);
      w[DATA_W-1-i] = do_q;
    end
    cs_down();
    chk("R3 R4 R5 R6 R7 read data", 32'(w), 32'(mem_m[a]));
  endtask

  task automatic op_wen(input int extra);
    cs_up(); send_cmd(0, 2'b00, ext_addr(2'b11)); junk(extra);
    chk("R10 R11 wen entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down(); wen_m = 1;
  endtask

  task automatic op_wds(input int extra);
    cs_up(); send_cmd(0, 2'b00, ext_addr(2'b00)); junk(extra);
    chk("R10 R11 wds entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down(); wen_m = 0;
  endtask

  task automatic op_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input int zeros, input string tag);
    cs_up(); send_cmd(zeros, 2'b01, a); send_data(d, DATA_W);
    chk("R10 write entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down();
    if (wen_m) mem_m[a] = d;
    finish_mod(wen_m, tag);
  endtask

  task automatic op_erase(input logic [ADDR_W-1:0] a, input int extra);
    cs_up(); send_cmd(0, 2'b11, a); junk(extra);
    chk("R10 erase entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down();
    if (wen_m) mem_m[a] = '1;
    finish_mod(wen_m, "R5");
  endtask

  task automatic op_eral();
    cs_up(); send_cmd(0, 2'b00, ext_addr(2'b10));
    chk("R10 eral entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down();
    if (wen_m) for (int i = 0; i < DEPTH; i++) mem_m[i] = '1;
    finish_mod(wen_m, "R6");
  endtask

  task automatic op_wral(input logic [DATA_W-1:0] d);
    cs_up(); send_cmd(0, 2'b00, ext_addr(2'b01)); send_data(d, DATA_W);
    chk("R10 wral entry hiz", {31'd0, do_oe}, 32'd0);
    cs_down();
    if (wen_m) for (int i = 0; i < DEPTH; i++) mem_m[i] = d;
    finish_mod(wen_m, "R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    chk("R1 reset oe", {31'd0, do_oe}, 32'd0);
    rst = 1'b0;
    tick(3);
    chk("R1 after reset oe", {31'd0, do_oe}, 32'd0);

    // R1: modifying command before any enable is ignored
    op_write(6'd5, 16'h1234, 0, "R1");

    // R6: enable then erase whole array, read every word back
    op_wen(0);
    op_eral();
    for (int i = 0; i < DEPTH; i++) do_read(ADDR_W'(i), 0);

    // R2: disable blocks write, read still works (R3)
    op_wds(2);
    op_write(6'd5, 16'hDEAD, 0, "R2");
    do_read(6'd5, 0);

    // R11: enable with trailing clocks, write, erase with trailing clocks
    op_wen(5);
    op_write(6'd5, 16'hA5C3, 0, "R4");
    do_read(6'd5, 0);
    op_write(6'd6, 16'h0F0F, 0, "R4");
    op_erase(6'd5, 4);
    do_read(6'd5, 0);
    do_read(6'd6, 0);

    // R8: write cut short by chip select
    cs_up(); send_cmd(0, 2'b01, 6'd7); send_data(16'h0000, 10); cs_down();
    finish_mod(1'b0, "R8");
    do_read(6'd7, 0);

    // R7: write all
    op_wral(16'h5A5A);
    do_read(6'd0, 0);
    do_read(6'd63, 0);
    do_read(6'd31, 0);

    // R13: leading zeros before start bit
    op_write(6'd12, 16'h8001, 3, "R13");
    do_read(6'd12, 2);

    // R12: full command sent while busy is ignored
    op_write(6'd10, 16'h3333, 0, "R4");
    cs_up(); send_cmd(0, 2'b01, 6'd9); send_data(16'h1111, DATA_W); cs_down();
    mem_m[9] = 16'h1111;
    cs_up();
    chk("R12 busy oe", {31'd0, do_oe}, 32'd1);
    send_cmd(0, 2'b01, 6'd10); send_data(16'h2222, DATA_W);
    chk("R12 still busy status", {31'd0, do_q}, 32'd0);
    chk("R12 status oe kept", {31'd0, do_oe}, 32'd1);
    tick(BUSY_LEN);
    cs_down();
    do_read(6'd10, 0);
    do_read(6'd9, 0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int sel;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      sel = $urandom_range(0, 19);
      a = ADDR_W'($urandom_range(0, DEPTH-1));
      d = DATA_W'($urandom);
      if (sel < 6)       do_read(a, $urandom_range(0, 2));
      else if (sel < 10) op_write(a, d, $urandom_range(0, 2), "R4");
      else if (sel < 13) op_erase(a, $urandom_range(0, 3));
      else if (sel < 16) op_wen($urandom_range(0, 4));
      else if (sel < 18) op_wds($urandom_range(0, 4));
      else if (sel == 18) op_eral();
      else               op_wral(d);
    end
    for (int i = 0; i < DEPTH; i += 9) do_read(ADDR_W'(i), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule